// File: doc/BRIEF.md
# Double-Precision Normalise-and-Round Unit

This unit is the last stage of a binary64 arithmetic pipeline. An upstream operator, such as an adder, multiplier, divider or square-root engine, leaves its result in unpacked form. That form is a sign, a signed biased exponent and a 64-bit significand that carries extra bits below the final precision. The unit turns this into the final packed IEEE 754 binary64 word. It also produces the inexact, underflow and overflow flags and merges them with any flags the operator already raised.

The datapath has four steps:

- A leading-zero count moves the first one of the significand to the top bit.
- A tiny result is denormalised with a sticky right shift.
- An increment chosen from the rounding mode and the sign is added.
- A carry out of the significand is folded back into the exponent before packing.

Infinities and already-flagged special values bypass rounding. A zero significand gives a signed zero. The whole path is combinational between an input register stage and an output register. A result appears one clock after the operand is presented with `in_valid`.

Top module: `nr_dp_round`

## Requirements
- R1: When `in_exp` equals 2047 and either `in_sig` is zero or any `in_flags` bit is set, the word is {`in_sign`, 2047, `in_sig`[62:11]} and `out_flags` equals `in_flags`. An exponent of 2047 with a nonzero significand and no incoming flags is rounded like any other number.
- R2: A zero `in_sig` (outside R1) gives {`in_sign`, 63 zero bits} and raises no new flag.
- R3: A nonzero input stands for `in_sig` × 2^(`in_exp` − 1085). The significand is shifted left until bit 63 is set, and the exponent drops by the same count. The packed exponent field is the adjusted exponent plus one, because the hidden bit at significand bit 63 lands in the exponent field. The fraction comes from significand bits 62:11.
- R4: An adjusted exponent below zero marks the result tiny. The significand is shifted right by the negated exponent, every bit shifted out is ORed into bit 0, a shift of 64 or more leaves only that sticky bit, and the exponent becomes zero. The result packs as a subnormal, or as the smallest normal if rounding carries into bit 63.
- R5: Mode 0 (nearest, ties to even) adds 0x400 when significand bit 11 is one and 0x3FF when it is zero.
- R6: Mode 3 (toward zero) adds nothing. Mode 1 (toward +inf) and mode 2 (toward −inf) add 0x7FF when they round away from zero for the given sign, that is mode 1 with sign 0 or mode 2 with sign 1, and nothing otherwise.
- R7: If the addition carries out of bit 63, the exponent rises by one, the significand is shifted right by one with its old bit 0 kept in bit 0, and the increment is added again.
- R8: Inexact (`out_flags` bit 0) is set when any of significand bits 10:0 are nonzero before the increment.
- R9: An exponent of 2046 or more after the carry step sets overflow (bit 2) and inexact. The word is infinity (field 2047, fraction 0) when the increment is nonzero, and the largest finite magnitude (field 2046, fraction all ones) when it is zero.
- R10: Underflow (bit 1) is set only when the result is tiny and also inexact.
- R11: Reset clears `out_valid`, `out_word` and `out_flags`. A result appears on the cycle after `in_valid` with `out_valid` high. While `in_valid` is low, `out_valid` is low and the word holds its last value.
- R12: For rounded and zero results, `out_flags` is the OR of `in_flags` with the new flags. Bit 3 only ever comes from `in_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 16 | Signed biased exponent |
| in_sig | input | 64 | Unnormalised significand with 11 round bits |
| in_rmode | input | 2 | 0 nearest, 1 toward +inf, 2 toward −inf, 3 toward zero |
| in_flags | input | 4 | Incoming flags: 0 inexact, 1 underflow, 2 overflow, 3 invalid |
| out_valid | output | 1 | Result present |
| out_word | output | 64 | Packed binary64 result |
| out_flags | output | 4 | Incoming flags merged with new flags |

## Verification
Several properties are checked on every accepted operand:

- the normaliser leaves bit 63 set for any nonzero significand;
- underflow and overflow never appear without inexact;
- toward-zero rounding never yields infinity on overflow;
- a result follows each accepted operand one cycle later, and the word holds when nothing is accepted.

The exact packed values can only be shown by the bench's scenarios. Those scenarios cover ties to even in both directions, each directed mode against each sign, the carry that renormalises an all-ones significand, subnormal packing with and without a carry into the normal range, the choice between infinity and the largest finite value on overflow, and the bypass of specials.

// File: rtl/nr_pkg.sv
// Shared types for the binary64 normalise-and-round unit.
// Assumes the flag and mode encodings below are used by the producer.
package nr_pkg;
    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_UP      = 2'd1,
        RM_DOWN    = 2'd2,
        RM_ZERO    = 2'd3
    } rmode_e;

    localparam int FLAG_W = 4;
    localparam int FL_INX = 0;
    localparam int FL_UNF = 1;
    localparam int FL_OVF = 2;
    localparam int FL_INV = 3;
endpackage

// File: rtl/nr_lead_norm.sv
// Leading-one normaliser: shifts a significand left until its top bit is
// set and lowers the exponent by the shift count. Assumes the caller
// handles a zero significand (the output is then zero, exponent unchanged).
module nr_lead_norm #(
    parameter int SIG_W = 64,
    parameter int EXP_W = 16
) (
    input  logic [SIG_W-1:0]        sig_in,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]        sig_out,
    output logic signed [EXP_W-1:0] exp_out
);
    localparam int CNT_W = $clog2(SIG_W) + 1;

    logic [CNT_W-1:0] lz;

    // Count leading zeros: the highest set bit wins.
    always_comb begin
        lz = '0;
        for (int i = 0; i < SIG_W; i++) begin
            if (sig_in[i]) lz = CNT_W'(SIG_W - 1 - i);
        end
    end

    // Apply the shift to significand and exponent.
    always_comb begin
        sig_out = sig_in << lz;
        exp_out = exp_in - EXP_W'(lz);
    end
endmodule

// File: rtl/nr_sticky_shr.sv
// Denormaliser: for a negative exponent shifts the significand right by its
// magnitude, ORs every lost bit into bit 0 and forces the exponent to zero.
// Assumes a normalised input; non-negative exponents pass unchanged.
module nr_sticky_shr #(
    parameter int SIG_W = 64,
    parameter int EXP_W = 16
) (
    input  logic [SIG_W-1:0]        sig_in,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]        sig_out,
    output logic signed [EXP_W-1:0] exp_out,
    output logic                    tiny
);
    localparam int SH_W = $clog2(SIG_W);

    logic signed [EXP_W-1:0] amt;
    logic [SH_W-1:0]         sh;
    logic [SIG_W-1:0]        lost_mask;
    logic                    sticky;

    // Shift amount and lost-bit mask.
    always_comb begin
        amt       = -exp_in;
        sh        = amt[SH_W-1:0];
        lost_mask = ~({SIG_W{1'b1}} << sh);
        sticky    = |(sig_in & lost_mask);
        tiny      = exp_in < 0;
    end

    // Select the jammed shift, the full collapse, or a pass-through.
    always_comb begin
        if (!tiny) begin
            sig_out = sig_in;
            exp_out = exp_in;
        end else if (amt >= $signed(EXP_W'(SIG_W))) begin
            sig_out = {{(SIG_W-1){1'b0}}, |sig_in};
            exp_out = '0;
        end else begin
            sig_out = (sig_in >> sh) | {{(SIG_W-1){1'b0}}, sticky};
            exp_out = '0;
        end
    end
endmodule

// File: rtl/nr_round_pack.sv
// Rounder and packer: picks the increment from mode and sign, folds a carry
// back into the exponent, derives inexact/underflow/overflow and assembles
// the packed word. Assumes bit 63 holds the hidden bit (or is zero when tiny).
module nr_round_pack
    import nr_pkg::*;
#(
    parameter int SIG_W  = 64,
    parameter int EXP_W  = 16,
    parameter int FRAC_W = 52,
    parameter int EXPF_W = 11
) (
    input  logic                    sign,
    input  logic [SIG_W-1:0]        sig_in,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic                    tiny,
    input  rmode_e                  rmode,
    output logic [EXPF_W+FRAC_W:0]  word,
    output logic [2:0]              flags
);
    localparam int WORD_W  = EXPF_W + FRAC_W + 1;
    localparam int DROP_W  = SIG_W - FRAC_W - 1;
    localparam int EXP_TOP = (1 << EXPF_W) - 1;
    localparam logic [SIG_W-1:0] HALF = SIG_W'(1) << (DROP_W - 1);
    localparam logic [SIG_W-1:0] ULP  = SIG_W'(1) << DROP_W;

    logic [SIG_W-1:0]        incr;
    logic [SIG_W:0]          first_sum;
    logic                    cout;
    logic [SIG_W-1:0]        pre;
    logic [SIG_W-1:0]        fin;
    logic signed [EXP_W-1:0] e1;
    logic                    inexact;
    logic                    ovf;
    logic [WORD_W-2:0]       kept;
    logic [WORD_W-2:0]       mag;

    // Rounding increment from mode, sign and the future LSB.
    always_comb begin
        case (rmode)
            RM_NEAREST: incr = sig_in[DROP_W] ? HALF : HALF - SIG_W'(1);
            RM_ZERO:    incr = '0;
            default:    incr = ((rmode == RM_UP) ^ sign) ? ULP - SIG_W'(1) : '0;
        endcase
    end

    // Carry detection and renormalisation before the final add.
    always_comb begin
        first_sum = {1'b0, sig_in} + {1'b0, incr};
        cout      = first_sum[SIG_W];
        pre       = cout ? ((sig_in >> 1) | {{(SIG_W-1){1'b0}}, sig_in[0]}) : sig_in;
        e1        = cout ? exp_in + EXP_W'(1) : exp_in;
        fin       = pre + incr;
    end

    // Flags.
    always_comb begin
        inexact = |pre[DROP_W-1:0];
        ovf     = e1 >= $signed(EXP_W'(EXP_TOP - 1));
        flags[FL_INX] = inexact | ovf;
        flags[FL_UNF] = tiny & inexact;
        flags[FL_OVF] = ovf;
    end

    // Packing: the hidden bit adds into the exponent field.
    always_comb begin
        kept = (WORD_W-1)'(fin >> DROP_W);
        if (ovf) begin
            if (incr != '0) mag = {{EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
            else            mag = {EXPF_W'(EXP_TOP - 1), {FRAC_W{1'b1}}};
        end else begin
            mag = {e1[EXPF_W-1:0], {FRAC_W{1'b0}}} + kept;
        end
        word = {sign, mag};
    end
endmodule

// File: rtl/nr_dp_round.sv
// Top of the binary64 normalise-and-round unit: bypasses specials and
// zeros, otherwise normalises, denormalises and rounds, and registers the
// packed result one cycle after in_valid. Synchronous active-low reset.
module nr_dp_round
    import nr_pkg::*;
#(
    parameter int SIG_W  = 64,
    parameter int EXP_W  = 16,
    parameter int FRAC_W = 52,
    parameter int EXPF_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [SIG_W-1:0]         in_sig,
    input  logic [1:0]               in_rmode,
    input  logic [FLAG_W-1:0]        in_flags,
    output logic                     out_valid,
    output logic [EXPF_W+FRAC_W:0]   out_word,
    output logic [FLAG_W-1:0]        out_flags
);
    localparam int WORD_W  = EXPF_W + FRAC_W + 1;
    localparam int EXP_TOP = (1 << EXPF_W) - 1;

    logic [SIG_W-1:0]        norm_sig;
    logic signed [EXP_W-1:0] norm_exp;
    logic [SIG_W-1:0]        sh_sig;
    logic signed [EXP_W-1:0] sh_exp;
    logic                    tiny;
    logic [WORD_W-1:0]       rnd_word;
    logic [2:0]              rnd_flags;
    logic                    special;
    logic [WORD_W-1:0]       res_word;
    logic [FLAG_W-1:0]       res_flags;

    nr_lead_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
        .sig_in (in_sig),
        .exp_in (in_exp),
        .sig_out(norm_sig),
        .exp_out(norm_exp)
    );

    nr_sticky_shr #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_shr (
        .sig_in (norm_sig),
        .exp_in (norm_exp),
        .sig_out(sh_sig),
        .exp_out(sh_exp),
        .tiny   (tiny)
    );

    nr_round_pack #(.SIG_W(SIG_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .EXPF_W(EXPF_W)) u_rnd (
        .sign  (in_sign),
        .sig_in(sh_sig),
        .exp_in(sh_exp),
        .tiny  (tiny),
        .rmode (rmode_e'(in_rmode)),
        .word  (rnd_word),
        .flags (rnd_flags)
    );

    // Choose between bypass, signed zero and the rounded value.
    always_comb begin
        special = (in_exp == $signed(EXP_W'(EXP_TOP))) && ((in_sig == '0) || (in_flags != '0));
        if (special) begin
            res_word  = {in_sign, {EXPF_W{1'b1}}, in_sig[SIG_W-2 -: FRAC_W]};
            res_flags = in_flags;
        end else if (in_sig == '0) begin
            res_word  = {in_sign, {(WORD_W-1){1'b0}}};
            res_flags = in_flags;
        end else begin
            res_word  = rnd_word;
            res_flags = in_flags | FLAG_W'(rnd_flags);
        end
    end

    // Output register with valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word  <= res_word;
                out_flags <= res_flags;
            end
        end
    end

    AST_NORM_MSB: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && norm_sig != '0) |-> norm_sig[SIG_W-1]); // R3
    AST_UNF_INX: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && rnd_flags[FL_UNF]) |-> rnd_flags[FL_INX]); // R10
    AST_OVF_INX: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && rnd_flags[FL_OVF]) |-> rnd_flags[FL_INX]); // R9
    AST_RTZ_FINITE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_rmode == 2'd3 && rnd_flags[FL_OVF]) |-> (rnd_word[WORD_W-2 -: EXPF_W] != {EXPF_W{1'b1}})); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R11
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> (!out_valid && $stable(out_word))); // R11
endmodule

// File: tb/nr_dp_round_tb.sv
`timescale 1ns/1ps
module nr_dp_round_tb;
    typedef struct packed {
        logic        s;
        logic [15:0] e;
        logic [63:0] sig;
        logic [1:0]  rm;
        logic [3:0]  fin;
        logic [63:0] word;
        logic [3:0]  fl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd1022, 64'h8000000000000000, 2'd0, 4'h0, 64'h3FF0000000000000, 4'h0, 8'd3},  // R3 1.0
        '{1'b0, 16'd1085, 64'h0000000000000001, 2'd0, 4'h0, 64'h3FF0000000000000, 4'h0, 8'd3},  // R3 full shift
        '{1'b1, 16'd1022, 64'hC000000000000000, 2'd0, 4'h0, 64'hBFF8000000000000, 4'h0, 8'd3},  // R3 -1.5
        '{1'b0, 16'd1022, 64'h8000000000000400, 2'd0, 4'h0, 64'h3FF0000000000000, 4'h1, 8'd5},  // R5 tie, even stays
        '{1'b0, 16'd1022, 64'h8000000000000C00, 2'd0, 4'h0, 64'h3FF0000000000002, 4'h1, 8'd5},  // R5 tie, odd goes up
        '{1'b0, 16'd1022, 64'h8000000000000401, 2'd0, 4'h0, 64'h3FF0000000000001, 4'h1, 8'd5},  // R5 above half
        '{1'b0, 16'd1022, 64'h8000000000000001, 2'd1, 4'h0, 64'h3FF0000000000001, 4'h1, 8'd6},  // R6 up, positive
        '{1'b1, 16'd1022, 64'h8000000000000001, 2'd1, 4'h0, 64'hBFF0000000000000, 4'h1, 8'd6},  // R6 up, negative
        '{1'b1, 16'd1022, 64'h8000000000000001, 2'd2, 4'h0, 64'hBFF0000000000001, 4'h1, 8'd6},  // R6 down, negative
        '{1'b0, 16'd1022, 64'h80000000000007FF, 2'd3, 4'h0, 64'h3FF0000000000000, 4'h1, 8'd6},  // R6 toward zero
        '{1'b0, 16'd1022, 64'hFFFFFFFFFFFFFFFF, 2'd0, 4'h0, 64'h4000000000000000, 4'h1, 8'd7},  // R7 carry out
        '{1'b0, 16'd2046, 64'h8000000000000000, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 8'd9},  // R9 nearest -> inf
        '{1'b0, 16'd2046, 64'h8000000000000000, 2'd3, 4'h0, 64'h7FEFFFFFFFFFFFFF, 4'h5, 8'd9},  // R9 zero -> max
        '{1'b0, 16'd2046, 64'h8000000000000000, 2'd2, 4'h0, 64'h7FEFFFFFFFFFFFFF, 4'h5, 8'd9},  // R9 down, positive -> max
        '{1'b1, 16'd2046, 64'h8000000000000000, 2'd2, 4'h0, 64'hFFF0000000000000, 4'h5, 8'd9},  // R9 down, negative -> inf
        '{1'b0, 16'd2045, 64'h8000000000000000, 2'd0, 4'h0, 64'h7FE0000000000000, 4'h0, 8'd9},  // R9 just below limit
        '{1'b0, 16'hFFFF, 64'h8000000000000000, 2'd0, 4'h0, 64'h0008000000000000, 4'h0, 8'd4},  // R4 exact subnormal
        '{1'b0, 16'hFFFF, 64'h8000000000000001, 2'd0, 4'h0, 64'h0008000000000000, 4'h3, 8'd10}, // R10 tiny inexact
        '{1'b0, 16'hFFFF, 64'hFFFFFFFFFFFFFFFF, 2'd0, 4'h0, 64'h0010000000000000, 4'h3, 8'd10}, // R10 rounds to normal
        '{1'b0, 16'hFF9C, 64'h8000000000000000, 2'd1, 4'h0, 64'h0000000000000001, 4'h3, 8'd4},  // R4 collapse to sticky
        '{1'b1, 16'd5,    64'h0000000000000000, 2'd0, 4'h0, 64'h8000000000000000, 4'h0, 8'd2},  // R2 signed zero
        '{1'b1, 16'd2047, 64'h0000000000000000, 2'd0, 4'h0, 64'hFFF0000000000000, 4'h0, 8'd1},  // R1 infinity bypass
        '{1'b0, 16'd2047, 64'h4000000000000000, 2'd0, 4'h8, 64'h7FF8000000000000, 4'h8, 8'd1},  // R1 flagged NaN bypass
        '{1'b0, 16'd1022, 64'h8000000000000000, 2'd0, 4'h8, 64'h3FF0000000000000, 4'h8, 8'd12}, // R12 flag merge
        '{1'b0, 16'd1022, 64'h8000000000000800, 2'd1, 4'h0, 64'h3FF0000000000001, 4'h0, 8'd8},  // R8 exact, no inexact
        '{1'b0, 16'd2047, 64'h8000000000000000, 2'd0, 4'h0, 64'h7FF0000000000000, 4'h5, 8'd1}   // R1 no bypass, rounds
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic signed [15:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic [1:0]  in_rmode = '0;
    logic [3:0]  in_flags = '0;
    logic        out_valid;
    logic [63:0] out_word;
    logic [3:0]  out_flags;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nr_dp_round u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_rmode(in_rmode), .in_flags(in_flags),
        .out_valid(out_valid), .out_word(out_word), .out_flags(out_flags)
    );

    task automatic check(input string req, input logic [68:0] act, input logic [68:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic drive(input vec_t v);
        in_sign  = v.s;
        in_exp   = v.e;
        in_sig   = v.sig;
        in_rmode = v.rm;
        in_flags = v.fin;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", {out_valid, out_word, out_flags}, {1'b0, 64'h0, 4'h0});
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R%0d vec%0d", VECS[i].req, i), {out_valid, out_word, out_flags},
                  {1'b1, VECS[i].word, VECS[i].fl});
        end
        // R11 hold: new inputs without in_valid must not change the output
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        check("R11 hold", {out_valid, out_word, out_flags}, {1'b0, VECS[NV-1].word, VECS[NV-1].fl});
        // R11 back-to-back: two operands on consecutive cycles
        drive(VECS[2]);
        in_valid = 1'b1;
        @(negedge clk);
        check("R11 b2b first", {out_valid, out_word, out_flags}, {1'b1, VECS[2].word, VECS[2].fl});
        drive(VECS[4]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 b2b second", {out_valid, out_word, out_flags}, {1'b1, VECS[4].word, VECS[4].fl});
        // R11 reset wins over a valid operand
        drive(VECS[3]);
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 reset priority", {out_valid, out_word, out_flags}, {1'b0, 64'h0, 4'h0});
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule